// File: doc/BRIEF.md
# Memory-Mapped Up-Counting Timer with Software-Compare Channel

The block is a 32-bit up-counting timer driven from a simple single-clock register bus (byte address, write enable, write data, combinational read data). A power-of-two prescaler turns the clock into count ticks. The counter steps once per tick and wraps to zero after it reaches a programmable modulo value, setting a sticky overflow flag. With the modulo left at all-ones the counter runs freely over the full 32-bit range and can be read at any time as a time base.

One compare channel watches the counter. In software-compare mode it sets a sticky match flag on the tick where the counter becomes equal to the compare value. Software can see and clear that flag, by writing one, from two places: the channel control register and a shared status register. The interrupt output is the match flag gated by a per-channel enable.

Two small state machines carry the mode decisions. The counter engine has states `RUN_HALT` and `RUN_COUNT`. A control write with counter mode 1 takes `RUN_HALT` to `RUN_COUNT` (transition *start*). A control write with any other mode takes `RUN_COUNT` back to `RUN_HALT` (transition *stop*). The channel has states `CH_IDLE` and `CH_SWCMP`. A channel control write with mode 0x4 takes it to `CH_SWCMP` (transition *arm*). A channel control write with any other mode returns it to `CH_IDLE` (transition *disarm*). Reset puts both machines in their idle state.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the control, counter, status, channel control and compare registers read 0, the modulo register reads 0xFFFFFFFF and `irq` is low. A read of an unmapped address returns 0.
- R2: The counter mode is control bits [4:3]. The value 1 makes the counter advance by one per prescaled tick. Any other value holds the count.
- R3: The prescaler setting is control bits [2:0], value p. With counting started at edge E0, ticks fall on edges E0 + k·2^p for k ≥ 1. Setting 3 gives one tick per 8 clocks and setting 7 gives one tick per 128 clocks.
- R4: A write of any data to the counter (offset 0x14) makes the count 0 at that edge and restarts the prescaler phase. The write wins over a tick at the same edge.
- R5: On a tick where the count equals the modulo value (offset 0x18), the count becomes 0 and the overflow flag (control bit 7) is set.
- R6: Writing control with bit 7 = 1 clears the overflow flag. Writing bit 7 = 0 leaves it unchanged. Bits [4:0] are always written.
- R7: If a flag's set event and a write-one clear of that flag fall on the same edge, the flag ends up set. This applies to both the overflow flag and the channel flag.
- R8: Channel mode is channel-control bits [5:2] (offset 0x20). In mode 0x4 the channel flag (bit 7) is set on the tick where the count becomes equal to the compare value (offset 0x24), including a wrap to 0. In any other mode the flag is never set.
- R9: The channel flag reads back as channel-control bit 7 and status bit 0 (offset 0x1C). Writing 1 to either bit clears it and writing 0 has no effect.
- R10: `irq` is high exactly while the channel flag and the interrupt enable (channel-control bit 6) are both 1.
- R11: The modulo, compare, prescaler, counter-mode, channel-mode and interrupt-enable fields read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the bus and the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per high clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Channel interrupt request, level |

## Verification
Two functions can meet on one edge: the hardware setting a sticky flag, and software clearing that same flag with a write-one. For the overflow flag, the modulo is set to 5 and a control write that clears the flag is placed on the exact edge where the counter wraps. For the channel flag, a status write that clears the flag is placed on the edge where the counter reaches the compare value. In both cases the flag must read back as 1 after that edge. A second write one edge later, with no event present, must clear the flag, which shows the clear path itself works.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 32;
    localparam int ADDR_W = 8;
    localparam int PSC_W  = 3;
    localparam int CMOD_W = 2;
    localparam int CHM_W  = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_MODULO = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_CHCTL  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CMPVAL = 8'h24;

    localparam int CTRL_PSC_LSB  = 0;
    localparam int CTRL_CMOD_LSB = 3;
    localparam int CTRL_OVF_BIT  = 7;
    localparam int CH_MODE_LSB   = 2;
    localparam int CH_IE_BIT     = 6;
    localparam int CH_FLAG_BIT   = 7;
    localparam int STAT_CH0_BIT  = 0;

    localparam logic [CMOD_W-1:0] CMOD_TICK  = 2'd1;
    localparam logic [CHM_W-1:0]  CHM_SWCMP  = 4'h4;

    typedef enum logic {RUN_HALT, RUN_COUNT} run_state_e;
    typedef enum logic {CH_IDLE, CH_SWCMP} chan_state_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int P_W = PSC_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           restart,
    input  logic [P_W-1:0] psc,
    output logic           tick
);
    localparam int DIV_W = (2 ** P_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] limit;

    // limit = 2^psc - 1; setting 2^P_W-1 wraps the shift to 0 and gives all ones
    always_comb begin
        limit = (DIV_W'(1) << psc) - DIV_W'(1);
        tick  = run && (div_cnt >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!run || restart || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + DIV_W'(1);
        end
    end

    // R3: after a tick, the next one follows at once only when the divide ratio is 1
    p_tick_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !restart) |=> (!run || (tick == (limit == '0))));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int C_W = CNT_W,
    parameter int M_W = CMOD_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctrl_we,
    input  logic [M_W-1:0] wr_mode,
    input  logic           ovf_w1c,
    input  logic           cnt_clr,
    input  logic           tick,
    input  logic [C_W-1:0] modulo,
    output logic           run,
    output logic           adv,
    output logic [C_W-1:0] count,
    output logic [C_W-1:0] cnt_next,
    output logic           ovf
);
    run_state_e state, state_nxt;
    logic       wrap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RUN_HALT;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions: start / stop on control writes
    always_comb begin
        state_nxt = state;
        unique case (state)
            RUN_HALT:  if (ctrl_we && (wr_mode == M_W'(CMOD_TICK)))  state_nxt = RUN_COUNT;
            RUN_COUNT: if (ctrl_we && (wr_mode != M_W'(CMOD_TICK)))  state_nxt = RUN_HALT;
            default:   state_nxt = RUN_HALT;
        endcase
    end

    // outputs of the engine
    always_comb begin
        run      = (state == RUN_COUNT);
        adv      = tick && !cnt_clr;
        wrap     = adv && (count == modulo);
        cnt_next = (count == modulo) ? '0 : count + C_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (cnt_clr) begin
            count <= '0;
        end else if (adv) begin
            count <= cnt_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (wrap) begin
            ovf <= 1'b1;
        end else if (ovf_w1c) begin
            ovf <= 1'b0;
        end
    end

    p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RUN_HALT && !cnt_clr) |=> $stable(count));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_clr && (count != modulo)) |=> (count == $past(count) + C_W'(1)));
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (count == '0));
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_clr && (count == modulo)) |=> (count == '0 && ovf));
    p_ovf_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_w1c && !(tick && !cnt_clr && (count == modulo))) |=> !ovf);
    p_ovf_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_w1c && tick && !cnt_clr && (count == modulo)) |=> ovf);
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
    import tmr_pkg::*;
#(
    parameter int C_W = CNT_W,
    parameter int H_W = CHM_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           chctl_we,
    input  logic [H_W-1:0] wr_mode,
    input  logic           flag_w1c,
    input  logic           adv,
    input  logic [C_W-1:0] cnt_next,
    input  logic [C_W-1:0] cmp_val,
    output logic           armed,
    output logic           flag
);
    chan_state_e state, state_nxt;
    logic        match;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions: arm / disarm on channel-control writes
    always_comb begin
        state_nxt = state;
        unique case (state)
            CH_IDLE:  if (chctl_we && (wr_mode == H_W'(CHM_SWCMP)))  state_nxt = CH_SWCMP;
            CH_SWCMP: if (chctl_we && (wr_mode != H_W'(CHM_SWCMP)))  state_nxt = CH_IDLE;
            default:  state_nxt = CH_IDLE;
        endcase
    end

    // outputs of the channel
    always_comb begin
        armed = (state == CH_SWCMP);
        match = armed && adv && (cnt_next == cmp_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (match) begin
            flag <= 1'b1;
        end else if (flag_w1c) begin
            flag <= 1'b0;
        end
    end

    p_match_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag);
    p_idle_no_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !flag) |=> !flag);
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_w1c) |=> flag);
    p_flag_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_w1c && match) |=> flag);
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
    import tmr_pkg::*;
#(
    parameter int C_W = CNT_W,
    parameter int A_W = ADDR_W,
    parameter int P_W = PSC_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] bus_addr,
    input  logic           bus_we,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           irq
);
    localparam int M_W = CMOD_W;
    localparam int H_W = CHM_W;

    logic           we_ctrl, we_count, we_mod, we_stat, we_chctl, we_cmp;
    logic [P_W-1:0] psc_q;
    logic [M_W-1:0] cmod_q;
    logic [C_W-1:0] modulo_q, cmp_q;
    logic [H_W-1:0] chmode_q;
    logic           ie_q;
    logic           run, adv, tick, ovf, ch_flag, armed, ch_w1c;
    logic [C_W-1:0] count, cnt_next;

    // write decode
    always_comb begin
        we_ctrl  = bus_we && (bus_addr == A_W'(OFS_CTRL));
        we_count = bus_we && (bus_addr == A_W'(OFS_COUNT));
        we_mod   = bus_we && (bus_addr == A_W'(OFS_MODULO));
        we_stat  = bus_we && (bus_addr == A_W'(OFS_STATUS));
        we_chctl = bus_we && (bus_addr == A_W'(OFS_CHCTL));
        we_cmp   = bus_we && (bus_addr == A_W'(OFS_CMPVAL));
        ch_w1c   = (we_stat && bus_wdata[STAT_CH0_BIT]) ||
                   (we_chctl && bus_wdata[CH_FLAG_BIT]);
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q    <= '0;
            cmod_q   <= '0;
            modulo_q <= '1;
            chmode_q <= '0;
            ie_q     <= 1'b0;
            cmp_q    <= '0;
        end else begin
            if (we_ctrl) begin
                psc_q  <= bus_wdata[CTRL_PSC_LSB +: P_W];
                cmod_q <= bus_wdata[CTRL_CMOD_LSB +: M_W];
            end
            if (we_mod)   modulo_q <= bus_wdata[C_W-1:0];
            if (we_chctl) begin
                chmode_q <= bus_wdata[CH_MODE_LSB +: H_W];
                ie_q     <= bus_wdata[CH_IE_BIT];
            end
            if (we_cmp)   cmp_q <= bus_wdata[C_W-1:0];
        end
    end

    tmr_prescaler #(.P_W(P_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (we_count),
        .psc     (psc_q),
        .tick    (tick)
    );

    tmr_counter #(.C_W(C_W), .M_W(M_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (we_ctrl),
        .wr_mode  (bus_wdata[CTRL_CMOD_LSB +: M_W]),
        .ovf_w1c  (we_ctrl && bus_wdata[CTRL_OVF_BIT]),
        .cnt_clr  (we_count),
        .tick     (tick),
        .modulo   (modulo_q),
        .run      (run),
        .adv      (adv),
        .count    (count),
        .cnt_next (cnt_next),
        .ovf      (ovf)
    );

    tmr_compare #(.C_W(C_W), .H_W(H_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .chctl_we (we_chctl),
        .wr_mode  (bus_wdata[CH_MODE_LSB +: H_W]),
        .flag_w1c (ch_w1c),
        .adv      (adv),
        .cnt_next (cnt_next),
        .cmp_val  (cmp_q),
        .armed    (armed),
        .flag     (ch_flag)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_W'(OFS_CTRL): begin
                bus_rdata[CTRL_PSC_LSB +: P_W]  = psc_q;
                bus_rdata[CTRL_CMOD_LSB +: M_W] = cmod_q;
                bus_rdata[CTRL_OVF_BIT]         = ovf;
            end
            A_W'(OFS_COUNT):  bus_rdata[C_W-1:0] = count;
            A_W'(OFS_MODULO): bus_rdata[C_W-1:0] = modulo_q;
            A_W'(OFS_STATUS): bus_rdata[STAT_CH0_BIT] = ch_flag;
            A_W'(OFS_CHCTL): begin
                bus_rdata[CH_MODE_LSB +: H_W] = chmode_q;
                bus_rdata[CH_IE_BIT]          = ie_q;
                bus_rdata[CH_FLAG_BIT]        = ch_flag;
            end
            A_W'(OFS_CMPVAL): bus_rdata[C_W-1:0] = cmp_q;
            default:          bus_rdata = '0;
        endcase
    end

    assign irq = ch_flag && ie_q;

    // R2: the engine runs exactly when the stored counter mode selects ticking
    p_run_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run == (cmod_q == M_W'(CMOD_TICK)));
    // R8: the channel is armed exactly when the stored channel mode is software compare
    p_armed_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed == (chmode_q == H_W'(CHM_SWCMP)));
    // R10: a masked channel never requests an interrupt
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q |-> !irq);
endmodule

// File: tb/tick_cmp_timer_tb.sv
`timescale 1ns/100ps
module tick_cmp_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  mon_ev;

    localparam logic [7:0] A_CTRL = 8'h10, A_CNT = 8'h14, A_MOD = 8'h18,
                           A_STAT = 8'h1C, A_CHC = 8'h20, A_CMP = 8'h24;

    tick_cmp_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    // monitor: pops the expected item and compares against the live outputs
    always @(mon_ev) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = it.is_irq ? {31'b0, irq} : bus_rdata;
        n_chk++;
        if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
        end
    end

    task automatic push(bit is_irq, logic [7:0] a, logic [31:0] e, string tag);
        item_t it;
        it.is_irq = is_irq; it.addr = a; it.exp = e; it.tag = tag;
        q.push_back(it);
        -> mon_ev;
        #0.2;
    endtask

    task automatic chk(logic [7:0] a, logic [31:0] e, string tag);
        bus_addr = a;
        #0.2;
        push(1'b0, a, e, tag);
    endtask

    task automatic chk_irq(bit e, string tag);
        push(1'b1, 8'h00, {31'b0, e}, tag);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // reset state
        chk(A_CTRL, 32'h0, "R1 ctrl");
        chk(A_CNT,  32'h0, "R1 count");
        chk(A_MOD,  32'hFFFF_FFFF, "R1 modulo");
        chk(A_STAT, 32'h0, "R1 status");
        chk(A_CHC,  32'h0, "R1 chctl");
        chk(A_CMP,  32'h0, "R1 compare");
        chk(8'h28,  32'h0, "R1 unmapped");
        chk_irq(1'b0, "R1 irq");

        // divide by 1 counting
        wr(A_CTRL, 32'h08);
        chk(A_CNT, 32'd0, "R2 start");
        idle(5);
        chk(A_CNT, 32'd5, "R2 count per tick");
        chk(A_CTRL, 32'h08, "R11 ctrl readback");

        // counter write clears
        wr(A_CNT, 32'h1234);
        chk(A_CNT, 32'd0, "R4 write clears");
        idle(3);
        chk(A_CNT, 32'd3, "R4 restart");

        // mode 2 holds the count (tick still lands on the stopping edge)
        wr(A_CTRL, 32'h10);
        chk(A_CTRL, 32'h10, "R11 mode field");
        chk(A_CNT, 32'd4, "R2 stop edge");
        idle(10);
        chk(A_CNT, 32'd4, "R2 hold");

        // prescale 8
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h0B);
        idle(7);
        chk(A_CNT, 32'd0, "R3 div8 before");
        idle(1);
        chk(A_CNT, 32'd1, "R3 div8 first");
        idle(8);
        chk(A_CNT, 32'd2, "R3 div8 second");

        // prescale 128
        wr(A_CTRL, 32'h00);
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h0F);
        idle(127);
        chk(A_CNT, 32'd0, "R3 div128 before");
        idle(1);
        chk(A_CNT, 32'd1, "R3 div128 first");

        // modulo wrap
        wr(A_CTRL, 32'h00);
        wr(A_MOD, 32'd5);
        chk(A_MOD, 32'd5, "R11 modulo readback");
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h08);
        idle(5);
        chk(A_CNT, 32'd5, "R5 at modulo");
        chk(A_CTRL, 32'h08, "R5 no flag yet");
        idle(1);
        chk(A_CNT, 32'd0, "R5 wrapped");
        chk(A_CTRL, 32'h88, "R5 overflow set");

        // overflow write-one-to-clear
        wr(A_CTRL, 32'h08);
        chk(A_CTRL, 32'h88, "R6 write zero keeps flag");
        wr(A_CTRL, 32'h00);
        wr(A_CTRL, 32'h80);
        chk(A_CTRL, 32'h00, "R6 write one clears");

        // overflow set and clear on the same edge
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h08);
        idle(5);
        wr(A_CTRL, 32'h88);
        chk(A_CTRL, 32'h88, "R7 overflow set wins");
        chk(A_CNT, 32'd0, "R5 wrap on collision edge");
        wr(A_CTRL, 32'h88);
        chk(A_CTRL, 32'h08, "R7 later clear works");
        wr(A_CTRL, 32'h00);
        wr(A_MOD, 32'hFFFF_FFFF);

        // software compare match
        wr(A_CNT, 32'h0);
        wr(A_CMP, 32'd10);
        chk(A_CMP, 32'd10, "R11 compare readback");
        wr(A_CHC, 32'h50);
        chk(A_CHC, 32'h50, "R11 chctl readback");
        wr(A_CTRL, 32'h08);
        idle(9);
        chk(A_CNT, 32'd9, "R8 before match");
        chk(A_STAT, 32'h0, "R8 no flag before match");
        chk_irq(1'b0, "R10 irq low before match");
        idle(1);
        chk(A_CHC, 32'hD0, "R8 flag in chctl");
        chk(A_STAT, 32'h1, "R9 flag in status");
        chk_irq(1'b1, "R10 irq high");

        // clear paths
        wr(A_STAT, 32'h0);
        chk(A_STAT, 32'h1, "R9 status write zero");
        wr(A_CHC, 32'h50);
        chk(A_CHC, 32'hD0, "R9 chctl write zero");
        wr(A_STAT, 32'h1);
        chk(A_STAT, 32'h0, "R9 status clear");
        chk_irq(1'b0, "R10 irq drops");
        wr(A_CNT, 32'h0);
        idle(10);
        chk(A_CHC, 32'hD0, "R8 second match");
        wr(A_CHC, 32'hD0);
        chk(A_CHC, 32'h50, "R9 chctl clear");
        chk_irq(1'b0, "R10 irq after chctl clear");

        // interrupt masked
        wr(A_CHC, 32'h10);
        wr(A_CNT, 32'h0);
        idle(10);
        chk(A_STAT, 32'h1, "R10 flag with mask");
        chk_irq(1'b0, "R10 masked irq");
        wr(A_STAT, 32'h1);

        // channel flag set and clear on the same edge
        wr(A_CHC, 32'h50);
        wr(A_CNT, 32'h0);
        idle(9);
        wr(A_STAT, 32'h1);
        chk(A_STAT, 32'h1, "R7 channel set wins");
        wr(A_STAT, 32'h1);
        chk(A_STAT, 32'h0, "R7 channel later clear");

        // channel disabled
        wr(A_CHC, 32'h40);
        wr(A_CNT, 32'h0);
        idle(12);
        chk(A_STAT, 32'h0, "R8 disabled no flag");
        chk_irq(1'b0, "R8 disabled no irq");

        // match on wrap to zero
        wr(A_CTRL, 32'h00);
        wr(A_MOD, 32'd3);
        wr(A_CMP, 32'd0);
        wr(A_CHC, 32'h50);
        wr(A_CNT, 32'h0);
        chk(A_STAT, 32'h0, "R8 no flag from clear");
        wr(A_CTRL, 32'h08);
        idle(3);
        chk(A_CNT, 32'd3, "R5 small modulo");
        chk(A_STAT, 32'h0, "R8 no early flag");
        idle(1);
        chk(A_CNT, 32'd0, "R5 small wrap");
        chk(A_STAT, 32'h1, "R8 match on wrap");
        chk(A_CTRL, 32'h88, "R5 overflow with match");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule